// File: doc/BRIEF.md
# Filtered External Interrupt Conditioner

This block takes one external interrupt pin and produces a one-cycle interrupt request pulse, together with a sticky request flag that software clears. The pin first passes through a two-flop synchronizer. An optional noise filter follows, and it lets the level through only after three samples in a row agree. The filter samples on a strobe that is selected by a field. An edge detector then picks rising edges, falling edges or both.

The request can be issued as soon as an edge is found. It can also be held until the next strobe of the count source of a companion timer. When the filter is on, requests stay aligned to the filter's sampling strobe whatever the timing bit says.

A second request source replaces the pin with a slow internal clock level. In that mode a request is raised once per slow-clock period or once per half period. A readback output shows the pin level before the filter.

Top module: `ext_irq_cond`

## Requirements
- R1: `pin_raw_o` equals the value `pin_i` had two clock edges earlier, whatever the setting of `flt_sel_i`.
- R2: After reset, `irq_pulse_o` and `irq_flag_o` are 0. A pin level that is steady across reset raises no request, whether that level is high or low.
- R3: `flt_sel_i` picks the filter sampling strobe: 00 = filter off, 01 = every clock, 10 = `stb_div8_i`, 11 = `stb_div32_i`. With the filter on, the filtered level changes only after three consecutive samples agree on the new level. With the filter off, a pin pulse one clock wide still gives a request.
- R4: `pol_i` selects the edge: 00 = rising, 01 = falling, 10 = both. 11 is reserved, and with it no request is ever issued.
- R5: With the filter off, the pin source and `tim_sel_i` = 1, the pulse appears 3 clock edges after a pin change. With the filter on every clock (01), it appears 5 edges after the change.
- R6: With the filter off, the pin source and `tim_sel_i` = 0, a detected edge is held until a count-source strobe. `cnt_src_i` picks the strobe: 00 = every clock, 01 = `stb_div8_i`, 10 = `stb_div32_i`, 11 = `stb_fast_i`. Several edges that wait for the same strobe give one request.
- R7: With the filter on and the pin source, a request pulse only follows a clock in which the selected sampling strobe was high, for either value of `tim_sel_i`.
- R8: With `src_sel_i` = 1, requests come from `slow_clk_i` and the pin is ignored. `pol_i` 00 gives one request per rising edge of the slow clock, 01 one per falling edge, 10 one per edge (the half-period rate), and 11 gives none.
- R9: `irq_flag_o` rises with each request pulse and stays set until `flag_clr_i` is high. A request in the same cycle as a clear leaves the flag set. Rewriting `pol_i`, `tim_sel_i` or `src_sel_i` may set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| stb_div8_i | input | 1 | Prescaler strobe, one clock in eight |
| stb_div32_i | input | 1 | Prescaler strobe, one clock in thirty-two |
| stb_fast_i | input | 1 | Strobe derived from a fast internal clock |
| slow_clk_i | input | 1 | Slow internal clock level, synchronous to clk |
| flt_sel_i | input | 2 | Filter sampling strobe select, 00 = off |
| pol_i | input | 2 | Edge select; rate select in slow-clock mode |
| tim_sel_i | input | 1 | 0 = wait for count-source strobe, 1 = issue at once |
| cnt_src_i | input | 2 | Timer count-source strobe select |
| src_sel_i | input | 1 | 0 = pin source, 1 = slow-clock source |
| flag_clr_i | input | 1 | Clears the request flag |
| irq_pulse_o | output | 1 | One-cycle interrupt request |
| irq_flag_o | output | 1 | Sticky request flag |
| pin_raw_o | output | 1 | Synchronized pin level before the filter |

## Verification
The bench sweeps every combination of filter, count source, timing and polarity settings. For each one it drives a clean rising and falling pin transition and counts the pulses. A wrong polarity decode would give the wrong count, and so would a reserved code that still fires. A hold that is never released would give no pulse, and an alignment bug would give a pulse in a cycle without the required strobe.

Glitches are driven just under and just at three samples wide. An off-by-one in the filter depth would either pass the short glitch or block the long one. Edges are piled up while the fast strobe is held low, which catches a pending edge that is lost or counted twice. A pin that is high through reset shows whether the filter history starts out wrong and fires. In slow-clock mode the pulses are counted per rate while the pin toggles, and a clear is made in the same cycle as a request to check that the set wins.

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int FLT_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       stb_div8_i,
  input  logic       stb_div32_i,
  input  logic       stb_fast_i,
  input  logic       slow_clk_i,
  input  logic [1:0] flt_sel_i,
  input  logic [1:0] pol_i,
  input  logic       tim_sel_i,
  input  logic [1:0] cnt_src_i,
  input  logic       src_sel_i,
  input  logic       flag_clr_i,
  output logic       irq_pulse_o,
  output logic       irq_flag_o,
  output logic       pin_raw_o
);

  logic                 s1, s2;
  logic [1:0]           wc;
  logic [FLT_DEPTH-1:0] hist, hist_n;
  logic                 flt, flt_n;
  logic                 slow_q, pend, req_q, flag_q;
  logic                 smp_stb, cs;

  wire warm   = (wc != 2'd2);
  wire flt_on = (flt_sel_i != 2'b00);
  wire defer  = !src_sel_i && !flt_on && !tim_sel_i;

  always_comb begin
    case (flt_sel_i)
      2'b01:   smp_stb = 1'b1;
      2'b10:   smp_stb = stb_div8_i;
      2'b11:   smp_stb = stb_div32_i;
      default: smp_stb = 1'b0;
    endcase
    case (cnt_src_i)
      2'b00:   cs = 1'b1;
      2'b01:   cs = stb_div8_i;
      2'b10:   cs = stb_div32_i;
      default: cs = stb_fast_i;
    endcase
  end

  assign hist_n = {hist[FLT_DEPTH-2:0], s2};

  always_comb begin
    flt_n = flt;
    if (!flt_on)                         flt_n = s2;
    else if (smp_stb && (&hist_n))       flt_n = 1'b1;
    else if (smp_stb && !(|hist_n))      flt_n = 1'b0;
  end

  function automatic logic pick(input logic [1:0] p, input logic r, input logic f);
    case (p)
      2'b00:   pick = r;
      2'b01:   pick = f;
      2'b10:   pick = r | f;
      default: pick = 1'b0;
    endcase
  endfunction

  wire pin_hit  = !warm && pick(pol_i, !flt && flt_n, flt && !flt_n);
  wire slow_hit = !warm && pick(pol_i, !slow_q && slow_clk_i, slow_q && !slow_clk_i);
  wire fire     = src_sel_i ? slow_hit :
                  defer     ? ((pend | pin_hit) & cs) : pin_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      wc <= 2'd0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      if (warm) wc <= wc + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      flt    <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      slow_q <= slow_clk_i;
      if (warm) begin
        hist <= {FLT_DEPTH{s1}};
        flt  <= s1;
      end else begin
        flt <= flt_n;
        if (!flt_on)      hist <= {FLT_DEPTH{s2}};
        else if (smp_stb) hist <= hist_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pend   <= defer ? ((pend | pin_hit) & ~cs) : 1'b0;
      req_q  <= fire;
      flag_q <= (flag_q & ~flag_clr_i) | fire;
    end
  end

  assign irq_pulse_o = req_q;
  assign irq_flag_o  = flag_q;
  assign pin_raw_o   = s2;

  AST_RAW_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (wc == 2'd2) |-> (pin_raw_o == $past(pin_i, 2))); // R1
  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm && flt_on && !smp_stb) |=> $stable(flt)); // R3
  AST_RSVD_POL: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_i == 2'b11) |=> !irq_pulse_o); // R4
  AST_DEFER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (defer && !cs) |=> !irq_pulse_o); // R6
  AST_FLT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel_i && flt_on && !smp_stb) |=> !irq_pulse_o); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> irq_flag_o); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o); // R9

endmodule

// File: tb/sim_ext_irq_cond.sv
module sim_ext_irq_cond;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b0, s8 = 1'b0, s32 = 1'b0, sf = 1'b0, slow = 1'b0;
  logic [1:0] flt = 2'b00, pol = 2'b00, cnt = 2'b00;
  logic tim = 1'b0, src = 1'b0, clr = 1'b0;
  logic pulse, flag, raw;
  int n_run = 0, n_fail = 0, npulse = 0, cyc = 0;
  bit fast_en = 1'b1;

  always #10 clk = ~clk;

  ext_irq_cond u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .stb_div8_i(s8), .stb_div32_i(s32),
    .stb_fast_i(sf), .slow_clk_i(slow), .flt_sel_i(flt), .pol_i(pol),
    .tim_sel_i(tim), .cnt_src_i(cnt), .src_sel_i(src), .flag_clr_i(clr),
    .irq_pulse_o(pulse), .irq_flag_o(flag), .pin_raw_o(raw));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic smp, cs;
    @(negedge clk);
    smp = (flt == 2'b01) ? 1'b1 : (flt == 2'b10) ? s8 : s32;
    cs  = (cnt == 2'b00) ? 1'b1 : (cnt == 2'b01) ? s8 : (cnt == 2'b10) ? s32 : sf;
    if (pulse) begin
      npulse++;
      if (!src && flt != 2'b00) chk(smp, "R7 pulse without sampling strobe", 0, 1);
      if (!src && flt == 2'b00 && !tim) chk(cs, "R6 pulse without count strobe", 0, 1);
    end
    cyc++;
    s8  = (cyc % 8) == 0;
    s32 = (cyc % 32) == 0;
    sf  = fast_en && ((cyc % 5) == 0);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    pin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(pulse == 0 && flag == 0, "R2 outputs after reset", {pulse, flag}, 0);
    npulse = 0;
    wait_n(20);
    chk(npulse == 0 && flag == 0, "R2 no request from level at reset", npulse, 0);
    chk(raw == 1, "R1 raw level after reset", raw, 1);

    flt = 2'b11;
    pin = 1'b0;
    tick();
    chk(raw == 1, "R1 raw not yet changed", raw, 1);
    tick();
    chk(raw == 0, "R1 raw two edges later with filter on", raw, 0);
    wait_n(120);

    for (int f = 0; f < 4; f++)
      for (int c = 0; c < 4; c++)
        for (int t = 0; t < 2; t++)
          for (int p = 0; p < 4; p++) begin
            int exp;
            flt = f[1:0]; cnt = c[1:0]; tim = t[0]; pol = p[1:0];
            wait_n(4);
            clr = 1'b1; tick(); clr = 1'b0;
            npulse = 0;
            pin = 1'b1; wait_n(120);
            pin = 1'b0; wait_n(120);
            exp = (p == 2) ? 2 : (p == 3) ? 0 : 1;
            chk(npulse == exp, $sformatf("R4 sweep f=%0d c=%0d t=%0d p=%0d", f, c, t, p), npulse, exp);
            chk(flag == (exp > 0), "R9 flag after sweep", flag, exp > 0);
          end

    flt = 2'b00; tim = 1'b1; pol = 2'b00;
    wait_n(5);
    pin = 1'b1; lat = 0;
    do begin tick(); lat++; end while (!pulse && lat < 20);
    chk(lat == 3, "R5 latency unfiltered", lat, 3);
    pin = 1'b0; wait_n(10);
    flt = 2'b01; wait_n(5);
    pin = 1'b1; lat = 0;
    do begin tick(); lat++; end while (!pulse && lat < 20);
    chk(lat == 5, "R5 latency filtered every clock", lat, 5);
    pin = 1'b0; wait_n(10);

    npulse = 0;
    pin = 1'b1; wait_n(2); pin = 1'b0; wait_n(20);
    chk(npulse == 0, "R3 two-sample glitch rejected", npulse, 0);
    pin = 1'b1; wait_n(3); pin = 1'b0; wait_n(20);
    chk(npulse == 1, "R3 three-sample pulse accepted", npulse, 1);
    flt = 2'b10; wait_n(40); npulse = 0;
    pin = 1'b1; wait_n(15); pin = 1'b0; wait_n(60);
    chk(npulse == 0, "R3 div8 glitch rejected", npulse, 0);
    flt = 2'b00; wait_n(5); npulse = 0;
    pin = 1'b1; wait_n(1); pin = 1'b0; wait_n(20);
    chk(npulse == 1, "R3 filter off passes one-clock pulse", npulse, 1);

    tim = 1'b0; cnt = 2'b11; pol = 2'b10; fast_en = 1'b0;
    wait_n(5); clr = 1'b1; tick(); clr = 1'b0; npulse = 0;
    pin = 1'b1; wait_n(10); pin = 1'b0; wait_n(10);
    chk(npulse == 0 && flag == 0, "R6 edges held without strobe", npulse, 0);
    fast_en = 1'b1; wait_n(12);
    chk(npulse == 1, "R6 held edges give one request", npulse, 1);

    src = 1'b1;
    for (int p = 0; p < 4; p++) begin
      int exp;
      pol = p[1:0]; slow = 1'b0; wait_n(5); npulse = 0;
      for (int k = 0; k < 20; k++) begin
        slow = ~slow; pin = ~pin; wait_n(10);
      end
      wait_n(5);
      exp = (p == 2) ? 20 : (p == 3) ? 0 : 10;
      chk(npulse == exp, $sformatf("R8 slow-clock rate p=%0d", p), npulse, exp);
    end

    pol = 2'b00; slow = 1'b0; wait_n(3);
    clr = 1'b1; tick();
    chk(flag == 0, "R9 clear drops flag", flag, 0);
    slow = 1'b1; tick(); clr = 1'b0;
    chk(pulse == 1 && flag == 1, "R9 set wins over clear", flag, 1);
    wait_n(5);
    chk(flag == 1, "R9 flag sticky", flag, 1);
    clr = 1'b1; tick(); clr = 1'b0;
    chk(flag == 0, "R9 flag cleared", flag, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule